// File: doc/BRIEF.md
# Bitmap Raster and Sound Scan Timer

This block produces every timing event needed to paint a monochrome bitmap held in DRAM onto a raster display. It also paces a once-per-line fetch of a sound/disk-speed word. It runs from the pixel clock. A word slot is as many pixel clocks as a fetched word has bits. Each line is a stretch of active slots followed by a stretch of retrace slots. A frame is made of visible lines followed by blanking lines.

The block tells the memory side when to fetch and from where. It does this with a one-cycle load strobe and a video byte address, plus a one-cycle sound strobe and a sound byte address. The memory side returns the pixel word on `pixData`, and the block captures it at the load strobe. That word is then shifted out serially on `pixOut`, most significant bit first. Ones are fed in behind it, so the beam is dark whenever nothing has been loaded. A high `pixOut` means a dark pixel.

Two base addresses are held for video and two for sound, and page-select inputs choose between them. The choice is taken once per frame, at the frame boundary. This boundary lies at the end of the second-to-last retrace slot of the last line, one slot before line 0 starts. After reset release the counters sit at the start of that second-to-last retrace slot of the last line, so line 0 starts 2×WORD_BITS clocks later.

Top module: `rasterScanTimer`

## Requirements
- R1: While reset is held, hsyncN is 0, vsyncN is 1, pixOut is 1, and pixLoad and sndStb are 0.
- R2: A line lasts (ACTIVE_SLOTS+RETRACE_SLOTS)×WORD_BITS clocks. hsyncN goes low after ACTIVE_SLOTS×WORD_BITS clocks of the line and stays low for RETRACE_SLOTS×WORD_BITS clocks.
- R3: A frame lasts TOTAL_LINES lines. vsyncN is low only during lines VSYNC_START to VSYNC_START+VSYNC_LINES-1, and it changes only when a line starts.
- R4: pixLoad is high for one clock, on the last clock of each slot that is followed by an active slot of a visible line. In that clock, vidAddr equals the video base plus 2×(line×ACTIVE_SLOTS+slot) for the slot about to be shown. The column count wraps at the end of the active slots without carrying into the line count.
- R5: sndStb is high for one clock, on the first clock of the last retrace slot of every line (visible and blanking), so there are exactly TOTAL_LINES strobes per frame.
- R6: At the n-th sound strobe after a frame boundary (n counted from 0), sndAddr equals the sound base plus 2×n.
- R7: pixOut shows the word captured at pixLoad from the next clock on, most significant bit first, one bit per clock. After the last bit it shows 1 until the next load.
- R8: The base addresses are chosen by vidPageSel and sndPageSel at the frame boundary (1 selects the alternate base). A change in the middle of a frame leaves the remaining fetches of that frame on the old base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous reset, active low |
| vidPageSel | input | 1 | 1 selects the alternate video base at the next frame boundary |
| sndPageSel | input | 1 | 1 selects the alternate sound base at the next frame boundary |
| vidMainBase | input | ADDR_W | Main video buffer byte address |
| vidAltBase | input | ADDR_W | Alternate video buffer byte address |
| sndMainBase | input | ADDR_W | Main sound/disk buffer byte address |
| sndAltBase | input | ADDR_W | Alternate sound/disk buffer byte address |
| pixData | input | WORD_BITS or 2×WORD_BITS | Pixel word returned for the current load |
| hsyncN | output | 1 | Horizontal sync, active low |
| vsyncN | output | 1 | Vertical sync, active low |
| pixOut | output | 1 | Serial pixel, 1 = dark |
| pixLoad | output | 1 | Video fetch request and shifter load strobe |
| vidAddr | output | ADDR_W | Video fetch byte address, valid with pixLoad |
| sndStb | output | 1 | Sound/disk word fetch strobe |
| sndAddr | output | ADDR_W | Sound fetch byte address, valid with sndStb |

## Verification
The assertions depend on three conditions. The frame geometry parameters must keep the sync window inside the blanking lines, clear of the last line. ACTIVE_SLOTS must be a power of two, so that the column count wraps by itself. There must be at least two retrace slots, so that the row carry and the sound fetch fall in different slots. The bench uses a reduced geometry (4 active and 3 retrace slots, 9 lines with 5 visible) that meets all three. It changes the page selects only on a falling clock edge, in the middle of a visible line, so their sampling at the frame boundary is never ambiguous. The pixel data changes on every falling edge, so each load captures a distinct word.

// File: rtl/vidScanPkg.sv
package vidScanPkg;

  // Strobes passed from the timing control to the address/pixel datapath.
  typedef struct packed {
    logic loadPix;     // capture pixData, advance the column count
    logic sndFetch;    // sound/disk word fetch slot begins
    logic rowCarry;    // end of the second-to-last retrace slot: row carry
    logic frameStart;  // rowCarry on the last line: frame boundary
  } scanStrobeT;

endpackage

// File: rtl/scanCtrl.sv
module scanCtrl
  import vidScanPkg::*;
#(
  parameter int WORD_BITS     = 16,
  parameter int ACTIVE_SLOTS  = 32,
  parameter int RETRACE_SLOTS = 12,
  parameter int VIS_LINES     = 342,
  parameter int TOTAL_LINES   = 370,
  parameter int VSYNC_START   = 342,
  parameter int VSYNC_LINES   = 4,
  parameter bit LONG_FETCH    = 1'b0
) (
  input  logic       clk,
  input  logic       rstN,
  output scanStrobeT st,
  output logic       hsyncN,
  output logic       vsyncN
);

  localparam int SLOTS_LINE = ACTIVE_SLOTS + RETRACE_SLOTS;
  localparam int PIX_W      = $clog2(WORD_BITS);
  localparam int SLOT_W     = $clog2(SLOTS_LINE);
  localparam int LINE_W     = $clog2(TOTAL_LINES);

  logic [PIX_W-1:0]  pixCnt;
  logic [SLOT_W-1:0] slotCnt;
  logic [LINE_W-1:0] lineCnt;

  logic              slotLast, lineLast, frameLast;
  logic [SLOT_W-1:0] upSlot;     // slot that follows the current one
  logic [LINE_W-1:0] upLine;     // line of that following slot
  logic [PIX_W-1:0]  nxtPix;
  logic [SLOT_W-1:0] nxtSlot;
  logic [LINE_W-1:0] nxtLine;
  logic              fetchPhase;

  function automatic logic inVsync(input logic [LINE_W-1:0] ln);
    return (int'(ln) >= VSYNC_START) && (int'(ln) < VSYNC_START + VSYNC_LINES);
  endfunction

  always_comb begin
    slotLast  = (pixCnt == PIX_W'(WORD_BITS - 1));
    lineLast  = (slotCnt == SLOT_W'(SLOTS_LINE - 1));
    frameLast = (lineCnt == LINE_W'(TOTAL_LINES - 1));
    upSlot    = lineLast ? '0 : slotCnt + 1'b1;
    upLine    = lineLast ? (frameLast ? '0 : lineCnt + 1'b1) : lineCnt;
    nxtPix    = slotLast ? '0 : pixCnt + 1'b1;
    nxtSlot   = slotLast ? upSlot : slotCnt;
    nxtLine   = slotLast ? upLine : lineCnt;
  end

  // Word fetches every slot, longword fetches every even slot.
  generate
    if (LONG_FETCH) begin : g_longFetch
      assign fetchPhase = ~upSlot[0];
    end else begin : g_wordFetch
      assign fetchPhase = 1'b1;
    end
  endgenerate

  always_comb begin
    st.loadPix    = slotLast && fetchPhase &&
                    (int'(upSlot) < ACTIVE_SLOTS) && (int'(upLine) < VIS_LINES);
    st.sndFetch   = lineLast && (pixCnt == '0);
    st.rowCarry   = slotLast && (slotCnt == SLOT_W'(SLOTS_LINE - 2));
    st.frameStart = st.rowCarry && frameLast;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pixCnt  <= '0;
      slotCnt <= SLOT_W'(SLOTS_LINE - 2);
      lineCnt <= LINE_W'(TOTAL_LINES - 1);
      hsyncN  <= 1'b0;
      vsyncN  <= 1'b1;
    end else begin
      pixCnt  <= nxtPix;
      slotCnt <= nxtSlot;
      lineCnt <= nxtLine;
      hsyncN  <= !(int'(nxtSlot) >= ACTIVE_SLOTS);
      vsyncN  <= !inVsync(nxtLine);
    end
  end

  // R5: the sound word is fetched inside horizontal retrace
  p_snd_in_retrace_r5: assert property (@(posedge clk) disable iff (!rstN)
    st.sndFetch |-> !hsyncN);

  // R4: a load is always followed by an active (non-retrace) clock
  p_load_before_active_r4: assert property (@(posedge clk) disable iff (!rstN)
    st.loadPix |=> hsyncN);

  // R3: vertical sync moves only together with the start of a line
  p_vsync_line_edge_r3: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(vsyncN) |-> $rose(hsyncN));

  // R5: video and sound fetches never share a clock
  p_fetch_exclusive_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(st.loadPix && st.sndFetch));

endmodule

// File: rtl/scanData.sv
module scanData
  import vidScanPkg::*;
#(
  parameter int WORD_BITS    = 16,
  parameter int ADDR_W       = 24,
  parameter int ACTIVE_SLOTS = 32,
  parameter int TOTAL_LINES  = 370,
  parameter bit LONG_FETCH   = 1'b0,
  localparam int SR_W        = LONG_FETCH ? 2 * WORD_BITS : WORD_BITS
) (
  input  logic              clk,
  input  logic              rstN,
  input  scanStrobeT        st,
  input  logic              vidPageSel,
  input  logic              sndPageSel,
  input  logic [ADDR_W-1:0] vidMainBase,
  input  logic [ADDR_W-1:0] vidAltBase,
  input  logic [ADDR_W-1:0] sndMainBase,
  input  logic [ADDR_W-1:0] sndAltBase,
  input  logic [SR_W-1:0]   pixData,
  output logic              pixOut,
  output logic [ADDR_W-1:0] vidAddr,
  output logic [ADDR_W-1:0] sndAddr
);

  localparam int COL_W    = $clog2(ACTIVE_SLOTS);
  localparam int ROW_W    = $clog2(TOTAL_LINES);
  localparam int SND_W    = $clog2(TOTAL_LINES + 1);
  localparam int COL_STEP = LONG_FETCH ? 2 : 1;
  localparam int VOFF_W   = ROW_W + COL_W + 1;
  localparam int SOFF_W   = SND_W + 1;

  logic [ADDR_W-1:0] vidBase, sndBase;
  logic [ROW_W-1:0]  rowCnt;
  logic [COL_W-1:0]  colCnt;
  logic [SND_W-1:0]  sndIdx;
  logic [SR_W-1:0]   shiftReg;
  logic [VOFF_W-1:0] vidOff;
  logic [SOFF_W-1:0] sndOff;

  // Base selection and row count: latched/cleared at the frame boundary,
  // row carry only at the end of retrace.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vidBase <= '0;
      sndBase <= '0;
      rowCnt  <= '0;
    end else if (st.frameStart) begin
      vidBase <= vidPageSel ? vidAltBase : vidMainBase;
      sndBase <= sndPageSel ? sndAltBase : sndMainBase;
      rowCnt  <= '0;
    end else if (st.rowCarry) begin
      rowCnt  <= rowCnt + 1'b1;
    end
  end

  // Column count wraps on its own width: no carry into the row.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           colCnt <= '0;
    else if (st.loadPix) colCnt <= colCnt + COL_W'(COL_STEP);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             sndIdx <= '0;
    else if (st.frameStart) sndIdx <= '0;
    else if (st.sndFetch)   sndIdx <= sndIdx + 1'b1;
  end

  // Pixel shifter: MSB out, ones shifted in so idle output is dark.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           shiftReg <= '1;
    else if (st.loadPix) shiftReg <= pixData;
    else                 shiftReg <= {shiftReg[SR_W-2:0], 1'b1};
  end

  always_comb begin
    vidOff  = {rowCnt, colCnt, 1'b0};
    sndOff  = {sndIdx, 1'b0};
    vidAddr = vidBase + ADDR_W'(vidOff);
    sndAddr = sndBase + ADDR_W'(sndOff);
    pixOut  = shiftReg[SR_W-1];
  end

  // R4: when the row carry arrives, the column count has wrapped to zero
  p_col_wrap_r4: assert property (@(posedge clk) disable iff (!rstN)
    st.rowCarry |-> (colCnt == '0));

  // R6: the sound index restarts only at the frame boundary
  p_snd_restart_r6: assert property (@(posedge clk) disable iff (!rstN)
    st.frameStart |=> (sndIdx == '0));

  // R7: without a load the shifter output turns dark once fed ones
  p_shift_fill_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!st.loadPix && pixOut) |=> pixOut || $past(shiftReg[SR_W-2]) == 1'b0);

endmodule

// File: rtl/rasterScanTimer.sv
module rasterScanTimer
  import vidScanPkg::*;
#(
  parameter int WORD_BITS     = 16,
  parameter int ADDR_W        = 24,
  parameter int ACTIVE_SLOTS  = 32,
  parameter int RETRACE_SLOTS = 12,
  parameter int VIS_LINES     = 342,
  parameter int TOTAL_LINES   = 370,
  parameter int VSYNC_START   = 345,
  parameter int VSYNC_LINES   = 4,
  parameter bit LONG_FETCH    = 1'b0
) (
  input  logic                                                  clk,
  input  logic                                                  rstN,
  input  logic                                                  vidPageSel,
  input  logic                                                  sndPageSel,
  input  logic [ADDR_W-1:0]                                     vidMainBase,
  input  logic [ADDR_W-1:0]                                     vidAltBase,
  input  logic [ADDR_W-1:0]                                     sndMainBase,
  input  logic [ADDR_W-1:0]                                     sndAltBase,
  input  logic [(LONG_FETCH ? 2 * WORD_BITS : WORD_BITS)-1:0]   pixData,
  output logic                                                  hsyncN,
  output logic                                                  vsyncN,
  output logic                                                  pixOut,
  output logic                                                  pixLoad,
  output logic [ADDR_W-1:0]                                     vidAddr,
  output logic                                                  sndStb,
  output logic [ADDR_W-1:0]                                     sndAddr
);

  scanStrobeT strobes;

  scanCtrl #(
    .WORD_BITS    (WORD_BITS),
    .ACTIVE_SLOTS (ACTIVE_SLOTS),
    .RETRACE_SLOTS(RETRACE_SLOTS),
    .VIS_LINES    (VIS_LINES),
    .TOTAL_LINES  (TOTAL_LINES),
    .VSYNC_START  (VSYNC_START),
    .VSYNC_LINES  (VSYNC_LINES),
    .LONG_FETCH   (LONG_FETCH)
  ) ctrl_i (
    .clk   (clk),
    .rstN  (rstN),
    .st    (strobes),
    .hsyncN(hsyncN),
    .vsyncN(vsyncN)
  );

  scanData #(
    .WORD_BITS   (WORD_BITS),
    .ADDR_W      (ADDR_W),
    .ACTIVE_SLOTS(ACTIVE_SLOTS),
    .TOTAL_LINES (TOTAL_LINES),
    .LONG_FETCH  (LONG_FETCH)
  ) data_i (
    .clk        (clk),
    .rstN       (rstN),
    .st         (strobes),
    .vidPageSel (vidPageSel),
    .sndPageSel (sndPageSel),
    .vidMainBase(vidMainBase),
    .vidAltBase (vidAltBase),
    .sndMainBase(sndMainBase),
    .sndAltBase (sndAltBase),
    .pixData    (pixData),
    .pixOut     (pixOut),
    .vidAddr    (vidAddr),
    .sndAddr    (sndAddr)
  );

  assign pixLoad = strobes.loadPix;
  assign sndStb  = strobes.sndFetch;

endmodule

// File: tb/rasterScanTimer_tb_top.sv
module rasterScanTimer_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WB   = 16;
  localparam int AW   = 24;
  localparam int ACT  = 4;
  localparam int RET  = 3;
  localparam int VIS  = 5;
  localparam int TL   = 9;
  localparam int VS0  = 6;
  localparam int VSL  = 2;
  localparam int SPL       = ACT + RET;
  localparam int LINE_CLKS = SPL * WB;
  localparam int FRAME     = TL * LINE_CLKS;
  localparam int S0        = FRAME - 2 * WB;
  localparam int RUN       = 4 * FRAME + 200;
  localparam int TOGGLE    = 1500;
  localparam int WD        = 20000;
  localparam logic [AW-1:0] VMAIN = 24'h100000;
  localparam logic [AW-1:0] VALT  = 24'h300000;
  localparam logic [AW-1:0] SMAIN = 24'h0A0000;
  localparam logic [AW-1:0] SALT  = 24'h0B0000;

  logic clk = 1'b0, rstN = 1'b0, vidSel = 1'b0, sndSel = 1'b0;
  logic [WB-1:0] pixData = '0;
  logic hsyncN, vsyncN, pixOut, pixLoad, sndStb;
  logic [AW-1:0] vidAddr, sndAddr;

  int total = 0, bad = 0;
  bit running = 0, done = 0, toggled = 0;

  rasterScanTimer #(
    .WORD_BITS(WB), .ADDR_W(AW), .ACTIVE_SLOTS(ACT), .RETRACE_SLOTS(RET),
    .VIS_LINES(VIS), .TOTAL_LINES(TL), .VSYNC_START(VS0), .VSYNC_LINES(VSL),
    .LONG_FETCH(1'b0)
  ) dut_i (
    .clk(clk), .rstN(rstN), .vidPageSel(vidSel), .sndPageSel(sndSel),
    .vidMainBase(VMAIN), .vidAltBase(VALT), .sndMainBase(SMAIN), .sndAltBase(SALT),
    .pixData(pixData), .hsyncN(hsyncN), .vsyncN(vsyncN), .pixOut(pixOut),
    .pixLoad(pixLoad), .vidAddr(vidAddr), .sndStb(sndStb), .sndAddr(sndAddr)
  );

  initial forever #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Reference model state
  typedef struct {
    bit hs, vs, ld, snd, po;
    logic [AW-1:0] va, sa;
  } expT;
  expT q[$];
  int mS = S0;
  logic [AW-1:0] mVB = '0, mSB = '0;
  logic [WB-1:0] mSr = '1;

  function automatic expT expectAt(input int s);
    expT e;
    int pix, slot, line, upSlot, upLine;
    pix  = s % WB;
    slot = (s / WB) % SPL;
    line = s / LINE_CLKS;
    upSlot = (slot == SPL - 1) ? 0 : slot + 1;
    upLine = (slot == SPL - 1) ? ((line + 1) % TL) : line;
    e.hs  = !(slot >= ACT);
    e.vs  = !(line >= VS0 && line < VS0 + VSL);
    e.snd = (slot == SPL - 1) && (pix == 0);
    e.ld  = (pix == WB - 1) && (upSlot < ACT) && (upLine < VIS);
    e.va  = mVB + AW'(2 * (upLine * ACT + upSlot));
    e.sa  = mSB + AW'(2 * ((line + 1) % TL));
    e.po  = mSr[WB-1];
    return e;
  endfunction

  // Driver side of the scoreboard: advance the model at each edge, queue expectation
  initial begin
    wait (running);
    forever begin
      @(posedge clk);
      begin
        expT cur;
        int pix, slot, line;
        cur  = expectAt(mS);
        pix  = mS % WB;
        slot = (mS / WB) % SPL;
        line = mS / LINE_CLKS;
        if (line == TL - 1 && slot == SPL - 2 && pix == WB - 1) begin
          mVB = vidSel ? VALT : VMAIN;
          mSB = sndSel ? SALT : SMAIN;
        end
        mSr = cur.ld ? pixData : {mSr[WB-2:0], 1'b1};
        mS  = (mS + 1) % FRAME;
        q.push_back(expectAt(mS));
      end
    end
  end

  // Monitor: pop and compare, plus interval checks
  initial begin
    int cyc = 0, lastHsFall = -1, lastVsFall = -1, sndCount = 0;
    bit prevHs = 1'b0, prevVs = 1'b1, seenVsRise = 1'b0;
    wait (running);
    forever begin
      @(negedge clk);
      if (done) break;
      cyc++;
      if (q.size() > 0) begin
        expT e;
        e = q.pop_front();
        check(hsyncN == e.hs, "R2", "hsyncN", hsyncN, e.hs);
        check(vsyncN == e.vs, "R3", "vsyncN", vsyncN, e.vs);
        check(pixLoad == e.ld, "R4", "pixLoad", pixLoad, e.ld);
        if (e.ld) check(vidAddr == e.va, "R4", "vidAddr", vidAddr, e.va);
        check(sndStb == e.snd, "R5", "sndStb", sndStb, e.snd);
        if (e.snd) check(sndAddr == e.sa, "R6", "sndAddr", sndAddr, e.sa);
        check(pixOut == e.po, "R7", "pixOut", pixOut, e.po);
      end
      if (sndStb) sndCount++;
      if (prevHs && !hsyncN) begin
        if (lastHsFall >= 0)
          check(cyc - lastHsFall == LINE_CLKS, "R2", "line period", cyc - lastHsFall, LINE_CLKS);
        lastHsFall = cyc;
      end
      if (!prevHs && hsyncN && lastHsFall >= 0)
        check(cyc - lastHsFall == RET * WB, "R2", "hsync width", cyc - lastHsFall, RET * WB);
      if (prevVs && !vsyncN) begin
        if (lastVsFall >= 0) begin
          check(cyc - lastVsFall == FRAME, "R3", "frame period", cyc - lastVsFall, FRAME);
          check(sndCount == TL, "R5", "sound strobes per frame", sndCount, TL);
        end
        lastVsFall = cyc;
        sndCount = 0;
      end
      if (!prevVs && vsyncN && lastVsFall >= 0) begin
        check(cyc - lastVsFall == VSL * LINE_CLKS, "R3", "vsync width",
              cyc - lastVsFall, VSL * LINE_CLKS);
        if (toggled) seenVsRise = 1'b1;
      end
      // R8: old bases until the frame boundary after the page-select change
      if (toggled && pixLoad)
        check(vidAddr[21] == seenVsRise, "R8", "video page", vidAddr[21], seenVsRise);
      if (toggled && sndStb)
        check(sndAddr[16] == seenVsRise, "R8", "sound page", sndAddr[16], seenVsRise);
      prevHs = hsyncN;
      prevVs = vsyncN;
    end
  end

  // Stimulus
  initial begin
    repeat (3) @(negedge clk);
    check(hsyncN == 1'b0, "R1", "reset hsyncN", hsyncN, 0);
    check(vsyncN == 1'b1, "R1", "reset vsyncN", vsyncN, 1);
    check(pixOut == 1'b1, "R1", "reset pixOut", pixOut, 1);
    check(pixLoad == 1'b0, "R1", "reset pixLoad", pixLoad, 0);
    check(sndStb == 1'b0, "R1", "reset sndStb", sndStb, 0);
    rstN = 1'b1;
    running = 1;
    for (int c = 0; c < RUN; c++) begin
      @(negedge clk);
      pixData = WB'((c * 40503) ^ 23130);
      if (c == TOGGLE) begin
        vidSel = 1'b1;
        sndSel = 1'b1;
        toggled = 1;
      end
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  // Watchdog
  initial begin
    repeat (WD) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog run did not complete actual=%0d expected=%0d", WD, RUN);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule